// File: doc/BRIEF.md
# Limit-Checking Interrupt Aggregator

This block turns a stream of stored measurement readings into a single active-low interrupt. Nine measured quantities are monitored: two processor core supplies, four fixed supply rails, two fan tachometer counts and one temperature. Each reading arrives with a channel number from an external measurement sequencer. When a reading is stored, it is compared against that channel's upper and lower limit. The result rewrites that channel's status bit. A tenth status bit copies an externally latched chassis-intrusion signal and is never compared against limits.

A host reaches the block through a small 8-bit register port. Through it the host sets the limits, reads back stored values and status, sets per-source mask bits and controls the interrupt with an enable bit and a clear bit in a configuration byte. The interrupt pin is active when any unmasked status bit is set, enable is 1 and clear is 0. It is modelled as a logic level plus an output-enable that is high only while the pin pulls low.

Register map (8-bit addresses):

| Address | Contents |
|---|---|
| 0x00 | configuration, read/write; bit 1 is interrupt enable, bit 3 is interrupt clear |
| 0x01 | status bits 7..0, read only |
| 0x02 | status bits 9..8 in data bits 1..0, read only; bit 9 is intrusion |
| 0x03 | mask bits 7..0 |
| 0x04 | mask bits 9..8 in data bits 1..0 |
| 0x10+c | high limit of channel c |
| 0x20+c | low limit of channel c |
| 0x30+c | last stored reading of channel c, read only |

Channels 6 and 7 are the fans.

Top module: `lim_irq_top`

## Requirements
- R1: One cycle after a reading is stored for channel c (meas_valid high, meas_chan = c < 9), status bit c is 1 if the reading is strictly greater than the high limit of channel c.
- R2: On the same kind of update, status bit c is 0 when the reading lies within both limits, and a reading equal to either limit counts as within them. A reading strictly below the low limit sets status bit c to 1 on a channel that is not a fan.
- R3: A reading stored for channel c leaves every other measurement status bit unchanged.
- R4: For the fan channels 6 and 7, the low limit is not checked: a reading below the low limit but not above the high limit gives status 0.
- R5: Status bit 9 (data bit 1 at address 0x02) takes the value of intrusion_in sampled at the previous clock edge, whatever the limits are.
- R6: A mask bit of 1 at address 0x03/0x04 stops its status bit from asserting the interrupt, even when that status bit is 1.
- R7: When configuration bit 1 is 1 and bit 3 is 0, int_n is 0 while any unmasked status bit is 1.
- R8: int_n is 1 whenever configuration bit 1 is 0 or configuration bit 3 is 1, regardless of status.
- R9: After reset, configuration reads 0x00, status reads 0, mask reads 0xFF and 0x03, every high limit reads 0xFF, every low limit reads 0x00, int_n is 1 and int_oe is 0.
- R10: Host writes to the status addresses 0x01 and 0x02 have no effect on the status read back.
- R11: Limits written at 0x10+c and 0x20+c read back at the same addresses, and the last stored reading of channel c reads at 0x30+c.
- R12: int_oe is 1 exactly when int_n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| reg_we | input | 1 | host write strobe |
| reg_addr | input | 8 | host register address |
| reg_wdata | input | 8 | host write data |
| reg_rdata | output | 8 | host read data, combinational from reg_addr |
| meas_valid | input | 1 | a new reading is stored this cycle |
| meas_chan | input | 4 | channel of the reading, 0 to 8 |
| meas_data | input | 8 | reading value |
| intrusion_in | input | 1 | externally latched chassis-intrusion level |
| int_n | output | 1 | interrupt level, active low |
| int_oe | output | 1 | high while the interrupt pin is actively pulled low |

## Verification
A wrong status bit appears in the status read one cycle after the reading that set it. It also appears on int_n in that same cycle, provided the source is unmasked and the interrupt is enabled. A comparison fault at a limit boundary shows up only for a reading exactly equal to a limit. For this reason, readings at the limit and one count past it are both applied. A mask or configuration bit stored wrongly shows up on int_n at once, since the interrupt path after those registers holds no register. Isolation faults, where a status bit changes on another channel's update, show only when an unrelated bit was already set before that update, so such bits are prepared first.

// File: rtl/lim_irq_pkg.sv
package lim_irq_pkg;

    parameter int MEAS_N   = 9;
    parameter int DATA_W   = 8;
    parameter int CHAN_W   = 4;
    parameter int ADDR_W   = 8;
    localparam int STAT_N  = MEAS_N + 1;
    localparam int INTR_IX = MEAS_N;
    localparam logic [MEAS_N-1:0] FAN_SEL = 9'b0_1100_0000;

    localparam int CFG_EN_BIT  = 1;
    localparam int CFG_CLR_BIT = 3;

    localparam logic [ADDR_W-1:0] A_CFG    = 8'h00;
    localparam logic [ADDR_W-1:0] A_STAT_L = 8'h01;
    localparam logic [ADDR_W-1:0] A_STAT_H = 8'h02;
    localparam logic [ADDR_W-1:0] A_MASK_L = 8'h03;
    localparam logic [ADDR_W-1:0] A_MASK_H = 8'h04;
    localparam logic [3:0] PG_HI  = 4'h1;
    localparam logic [3:0] PG_LO  = 4'h2;
    localparam logic [3:0] PG_VAL = 4'h3;

    typedef logic [DATA_W-1:0] byte_t;

    typedef struct packed {
        logic en;
        logic clr;
    } irq_ctrl_t;

    typedef struct packed {
        logic  valid;
        logic [CHAN_W-1:0] chan;
        byte_t data;
    } meas_t;

    function automatic logic out_of_window(byte_t v, byte_t hi, byte_t lo, logic fan);
        return (v > hi) || (!fan && (v < lo));
    endfunction

endpackage

// File: rtl/lim_window_bank.sv
module lim_window_bank
    import lim_irq_pkg::*;
#(
    parameter int NM = MEAS_N,
    parameter int DW = DATA_W,
    parameter int CW = CHAN_W,
    parameter logic [NM-1:0] FANS = FAN_SEL
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     hi_we,
    input  logic                     lo_we,
    input  logic [CW-1:0]            wr_chan,
    input  logic [DW-1:0]            wr_data,
    input  meas_t                    meas,
    output logic [NM-1:0][DW-1:0]    hi_q,
    output logic [NM-1:0][DW-1:0]    lo_q,
    output logic [NM-1:0][DW-1:0]    val_q,
    output logic [NM-1:0]            upd,
    output logic                     verdict
);
    byte_t sel_hi, sel_lo;
    logic  sel_fan;

    for (genvar g = 0; g < NM; g++) begin : g_chan
        assign upd[g] = meas.valid && (meas.chan == CW'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                hi_q[g]  <= '1;
                lo_q[g]  <= '0;
                val_q[g] <= '0;
            end else begin
                if (hi_we && wr_chan == CW'(g)) hi_q[g] <= wr_data;
                if (lo_we && wr_chan == CW'(g)) lo_q[g] <= wr_data;
                if (upd[g]) val_q[g] <= meas.data;
            end
        end
    end

    // one shared comparator: only one channel is updated per cycle
    always_comb begin
        sel_hi  = '1;
        sel_lo  = '0;
        sel_fan = 1'b0;
        for (int i = 0; i < NM; i++) begin
            if (upd[i]) begin
                sel_hi  = hi_q[i];
                sel_lo  = lo_q[i];
                sel_fan = FANS[i];
            end
        end
        verdict = out_of_window(meas.data, sel_hi, sel_lo, sel_fan);
    end

endmodule

// File: rtl/lim_status_bank.sv
module lim_status_bank
    import lim_irq_pkg::*;
#(
    parameter int NM = MEAS_N,
    localparam int NS = NM + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NM-1:0] upd,
    input  logic          verdict,
    input  logic          intrusion_in,
    output logic [NS-1:0] status
);
    for (genvar g = 0; g < NM; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)         status[g] <= 1'b0;
            else if (upd[g]) status[g] <= verdict;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) status[NM] <= 1'b0;
        else     status[NM] <= intrusion_in;
    end

endmodule

// File: rtl/lim_ctrl_regs.sv
module lim_ctrl_regs
    import lim_irq_pkg::*;
#(
    parameter int NS = STAT_N,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic          mask_lo_we,
    input  logic          mask_hi_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] cfg_q,
    output logic [NS-1:0] mask_q,
    output irq_ctrl_t     ctrl
);
    localparam int WIDE = 2 * DW;

    logic [WIDE-1:0] mask_pad, mask_nxt;

    assign mask_pad = WIDE'(mask_q);
    assign mask_nxt = mask_lo_we ? {mask_pad[WIDE-1:DW], wdata}
                                 : {wdata, mask_pad[DW-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            mask_q <= '1;
        end else begin
            if (cfg_we) cfg_q <= wdata;
            if (mask_lo_we || mask_hi_we) mask_q <= mask_nxt[NS-1:0];
        end
    end

    assign ctrl.en  = cfg_q[CFG_EN_BIT];
    assign ctrl.clr = cfg_q[CFG_CLR_BIT];

endmodule

// File: rtl/lim_irq_gate.sv
module lim_irq_gate
    import lim_irq_pkg::*;
#(
    parameter int NS = STAT_N
) (
    input  logic [NS-1:0] status,
    input  logic [NS-1:0] mask,
    input  irq_ctrl_t     ctrl,
    output logic          int_n,
    output logic          int_oe
);
    logic pending;

    assign pending = |(status & ~mask);
    assign int_oe  = ctrl.en && !ctrl.clr && pending;
    assign int_n   = !int_oe;

endmodule

// File: rtl/lim_irq_top.sv
module lim_irq_top
    import lim_irq_pkg::*;
#(
    parameter int NM = MEAS_N,
    parameter int DW = DATA_W,
    parameter int CW = CHAN_W,
    parameter int AW = ADDR_W,
    localparam int NS = NM + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          meas_valid,
    input  logic [CW-1:0] meas_chan,
    input  logic [DW-1:0] meas_data,
    input  logic          intrusion_in,
    output logic          int_n,
    output logic          int_oe
);
    localparam int WIDE = 2 * DW;

    meas_t                 meas;
    logic [NM-1:0][DW-1:0] hi_q, lo_q, val_q;
    logic [NM-1:0]         upd;
    logic                  verdict;
    logic [NS-1:0]         status, mask_q;
    logic [DW-1:0]         cfg_q;
    irq_ctrl_t             ctrl;
    logic [3:0]            page, slot;
    logic                  slot_ok;
    logic [WIDE-1:0]       stat_pad, mask_pad;

    assign meas    = '{valid: meas_valid, chan: meas_chan, data: meas_data};
    assign page    = reg_addr[7:4];
    assign slot    = reg_addr[3:0];
    assign slot_ok = slot < 4'(NM);

    lim_window_bank #(.NM(NM), .DW(DW), .CW(CW), .FANS(FAN_SEL)) u_win (
        .clk(clk), .rst(rst),
        .hi_we(reg_we && page == PG_HI && slot_ok),
        .lo_we(reg_we && page == PG_LO && slot_ok),
        .wr_chan(CW'(slot)), .wr_data(reg_wdata),
        .meas(meas), .hi_q(hi_q), .lo_q(lo_q), .val_q(val_q),
        .upd(upd), .verdict(verdict)
    );

    lim_status_bank #(.NM(NM)) u_stat (
        .clk(clk), .rst(rst), .upd(upd), .verdict(verdict),
        .intrusion_in(intrusion_in), .status(status)
    );

    lim_ctrl_regs #(.NS(NS), .DW(DW)) u_ctrl (
        .clk(clk), .rst(rst),
        .cfg_we(reg_we && reg_addr == A_CFG),
        .mask_lo_we(reg_we && reg_addr == A_MASK_L),
        .mask_hi_we(reg_we && reg_addr == A_MASK_H),
        .wdata(reg_wdata), .cfg_q(cfg_q), .mask_q(mask_q), .ctrl(ctrl)
    );

    lim_irq_gate #(.NS(NS)) u_gate (
        .status(status), .mask(mask_q), .ctrl(ctrl),
        .int_n(int_n), .int_oe(int_oe)
    );

    assign stat_pad = WIDE'(status);
    assign mask_pad = WIDE'(mask_q);

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CFG:    reg_rdata = cfg_q;
            A_STAT_L: reg_rdata = stat_pad[DW-1:0];
            A_STAT_H: reg_rdata = stat_pad[WIDE-1:DW];
            A_MASK_L: reg_rdata = mask_pad[DW-1:0];
            A_MASK_H: reg_rdata = mask_pad[WIDE-1:DW];
            default: begin
                for (int i = 0; i < NM; i++) begin
                    if (slot == 4'(i)) begin
                        if (page == PG_HI)  reg_rdata = hi_q[i];
                        if (page == PG_LO)  reg_rdata = lo_q[i];
                        if (page == PG_VAL) reg_rdata = val_q[i];
                    end
                end
            end
        endcase
    end

endmodule

// File: rtl/lim_irq_chk.sv
module lim_irq_chk
    import lim_irq_pkg::*;
#(
    parameter int NM = MEAS_N,
    parameter int DW = DATA_W,
    parameter int CW = CHAN_W,
    localparam int NS = NM + 1
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  meas_valid,
    input logic [CW-1:0]         meas_chan,
    input logic [DW-1:0]         meas_data,
    input logic                  intrusion_in,
    input logic                  int_n,
    input logic                  int_oe,
    input logic [NS-1:0]         status,
    input logic [NS-1:0]         mask_q,
    input logic                  en,
    input logic                  clr,
    input logic [NM-1:0][DW-1:0] hi_q
);
    localparam logic [NS-1:0] MEAS_BITS = {1'b0, {NM{1'b1}}};

    logic [NS-1:0] prev_status, prev_oh, chan_oh;
    logic          have_prev;
    logic [DW-1:0] hi_sel;

    always_comb begin
        chan_oh = '0;
        hi_sel  = '1;
        for (int i = 0; i < NM; i++) begin
            if (meas_valid && meas_chan == CW'(i)) begin
                chan_oh[i] = 1'b1;
                hi_sel     = hi_q[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            have_prev   <= 1'b0;
            prev_status <= '0;
            prev_oh     <= '0;
        end else begin
            have_prev   <= 1'b1;
            prev_status <= status;
            prev_oh     <= chan_oh;
        end
    end

    assert_over_high_R1: assert property (@(posedge clk) disable iff (rst)
        ((|chan_oh) && meas_data > hi_sel) |=> status[$past(meas_chan)]);

    assert_others_hold_R3: assert property (@(posedge clk) disable iff (rst)
        have_prev |-> (((status ^ prev_status) & ~prev_oh & MEAS_BITS) == '0));

    assert_intrusion_follow_R5: assert property (@(posedge clk) disable iff (rst)
        !rst |=> status[NM] == $past(intrusion_in));

    assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        ((status & ~mask_q) == '0) |-> int_n);

    assert_int_low_R7: assert property (@(posedge clk) disable iff (rst)
        (en && !clr && |(status & ~mask_q)) |-> !int_n);

    assert_gate_off_R8: assert property (@(posedge clk) disable iff (rst)
        (!en || clr) |-> int_n);

    assert_reset_vals_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (mask_q == '1 && !en && !clr && int_n));

    assert_oe_match_R12: assert property (@(posedge clk) disable iff (rst)
        int_oe != int_n);

endmodule

bind lim_irq_top lim_irq_chk #(.NM(NM), .DW(DW), .CW(CW)) u_chk (
    .clk(clk), .rst(rst), .meas_valid(meas_valid), .meas_chan(meas_chan),
    .meas_data(meas_data), .intrusion_in(intrusion_in), .int_n(int_n),
    .int_oe(int_oe), .status(status), .mask_q(mask_q), .en(ctrl.en),
    .clr(ctrl.clr), .hi_q(hi_q)
);

// File: tb/lim_irq_top_tb_top.sv
module lim_irq_top_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       meas_valid = 1'b0;
    logic [3:0] meas_chan = '0;
    logic [7:0] meas_data = '0;
    logic       intrusion_in = 1'b0;
    logic       int_n, int_oe;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    lim_irq_top dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .meas_valid(meas_valid),
        .meas_chan(meas_chan), .meas_data(meas_data),
        .intrusion_in(intrusion_in), .int_n(int_n), .int_oe(int_oe)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic store(input logic [3:0] ch, input logic [7:0] v);
        @(negedge clk);
        meas_valid = 1'b1; meas_chan = ch; meas_data = v;
        @(negedge clk);
        meas_valid = 1'b0;
    endtask

    task automatic expect_reg(input logic [7:0] a, input logic [7:0] e, input string tag);
        logic [7:0] d;
        rd(a, d);
        chk(d === e, tag, d, e);
    endtask

    task automatic t_reset;
        expect_reg(8'h00, 8'h00, "R9 config");
        expect_reg(8'h01, 8'h00, "R9 status lo");
        expect_reg(8'h02, 8'h00, "R9 status hi");
        expect_reg(8'h03, 8'hFF, "R9 mask lo");
        expect_reg(8'h04, 8'h03, "R9 mask hi");
        expect_reg(8'h18, 8'hFF, "R9 high limit ch8");
        expect_reg(8'h20, 8'h00, "R9 low limit ch0");
        chk(int_n === 1'b1 && int_oe === 1'b0, "R9 int pins", {int_n, int_oe}, 2'b10);
    endtask

    task automatic t_regmap;
        wr(8'h10, 8'h80);
        wr(8'h20, 8'h40);
        expect_reg(8'h10, 8'h80, "R11 high ch0");
        expect_reg(8'h20, 8'h40, "R11 low ch0");
        store(4'd0, 8'h55);
        expect_reg(8'h30, 8'h55, "R11 value ch0");
    endtask

    task automatic t_window;
        store(4'd0, 8'h81);
        expect_reg(8'h01, 8'h01, "R1 above high");
        store(4'd0, 8'h80);
        expect_reg(8'h01, 8'h00, "R2 equal high");
        store(4'd0, 8'h3F);
        expect_reg(8'h01, 8'h01, "R2 below low");
        store(4'd0, 8'h40);
        expect_reg(8'h01, 8'h00, "R2 equal low");
    endtask

    task automatic t_isolation;
        wr(8'h12, 8'h10);
        store(4'd2, 8'h20);
        expect_reg(8'h01, 8'h04, "R3 ch2 set");
        store(4'd3, 8'h20);
        expect_reg(8'h01, 8'h04, "R3 ch3 update keeps ch2");
        store(4'd0, 8'h90);
        expect_reg(8'h01, 8'h05, "R3 ch0 set keeps ch2");
        store(4'd2, 8'h05);
        store(4'd0, 8'h50);
        expect_reg(8'h01, 8'h00, "R3 both cleared");
    endtask

    task automatic t_fan;
        wr(8'h16, 8'h90); wr(8'h26, 8'h50);
        wr(8'h15, 8'h90); wr(8'h25, 8'h50);
        store(4'd6, 8'h10);
        expect_reg(8'h01, 8'h00, "R4 fan below low ignored");
        store(4'd5, 8'h10);
        expect_reg(8'h01, 8'h20, "R4 non-fan below low flagged");
        store(4'd5, 8'h60);
        store(4'd6, 8'h91);
        expect_reg(8'h01, 8'h40, "R4 fan above high");
        store(4'd6, 8'h60);
    endtask

    task automatic t_intrusion;
        @(negedge clk); intrusion_in = 1'b1;
        @(negedge clk);
        expect_reg(8'h02, 8'h02, "R5 intrusion set");
        intrusion_in = 1'b0;
        @(negedge clk);
        expect_reg(8'h02, 8'h00, "R5 intrusion follows low");
    endtask

    task automatic t_gate;
        wr(8'h00, 8'h02);
        store(4'd0, 8'hF0);
        chk(int_n === 1'b1, "R6 masked source", int_n, 1);
        wr(8'h03, 8'hFE);
        chk(int_n === 1'b0, "R7 unmasked asserts", int_n, 0);
        chk(int_oe === 1'b1, "R12 oe while low", int_oe, 1);
        wr(8'h00, 8'h0A);
        chk(int_n === 1'b1, "R8 clear bit blocks", int_n, 1);
        chk(int_oe === 1'b0, "R12 oe released", int_oe, 0);
        wr(8'h00, 8'h00);
        chk(int_n === 1'b1, "R8 enable off blocks", int_n, 1);
        wr(8'h00, 8'h02);
        chk(int_n === 1'b0, "R7 re-enabled", int_n, 0);
        store(4'd0, 8'h50);
        chk(int_n === 1'b1, "R7 status cleared releases", int_n, 1);
        wr(8'h03, 8'hFF);
        wr(8'h04, 8'h00);
        @(negedge clk); intrusion_in = 1'b1;
        @(negedge clk);
        chk(int_n === 1'b0, "R6 intrusion unmasked", int_n, 0);
        wr(8'h04, 8'h02);
        chk(int_n === 1'b1, "R6 intrusion masked", int_n, 1);
        intrusion_in = 1'b0;
        wr(8'h00, 8'h00);
    endtask

    task automatic t_readonly;
        store(4'd1, 8'h00);
        wr(8'h11, 8'h20);
        store(4'd1, 8'h30);
        expect_reg(8'h01, 8'h02, "R10 status before write");
        wr(8'h01, 8'h00);
        expect_reg(8'h01, 8'h02, "R10 write lo ignored");
        wr(8'h02, 8'hFF);
        expect_reg(8'h02, 8'h00, "R10 write hi ignored");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_window();
        t_isolation();
        t_fan();
        t_intrusion();
        t_gate();
        t_readonly();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule